// File: doc/BRIEF.md
# Serial Sign-Magnitude Decimal Adder

This unit adds two signed decimal numbers of equal length that sit in a character-addressed memory. The result replaces the first operand. A caller supplies a digit count and two addresses, each pointing at the least significant character of an operand, and then pulses `start`. The unit walks upward through the digits one character at a time. Each address steps down by one per digit, so the most significant digit sits at the lowest address. For each digit it reads both operands and writes one result character back over the first operand.

Each character is six bits. Bits 3:0 hold a BCD digit and bits 5:4 are zone bits. The sign is carried in the low character, and the high character holds an overflow record. When the signs are alike the digits are summed with carry. When they differ the digits are subtracted with borrow. If the second magnitude turns out to be the larger one, a second pass rewrites the stored result as its ten's complement. Carries out of the top digit set sticky indicators, and the unit can be configured with one or two of them. An illegal character, or an overflow beyond the last available indicator, stops the unit in an alarm state that only reset clears.

The memory port is a plain synchronous port with no back-pressure. The memory must accept every cycle in which `mem_en` is high. Read data must appear on `mem_rdata` exactly one cycle after a read is issued.

Top module: `serial_decimal_adder`

## Requirements
- R1: After reset, `busy`, `done`, `alarm`, `ovf1` and `ovf2` are all low. No memory access (`mem_en`) or write happens while the unit is not busy.
- R2: A start with a digit count of 0 raises `done` on the following cycle and makes no memory access.
- R3: Digit i of an operand is at (base address − i). Bits 3:0 are the BCD digit, and bit 5 of the i=0 character is the sign (1 means negative). Results are written over operand A, and operand B is left unchanged.
- R4: When the signs are alike, the result magnitude is |A|+|B| and the result sign is the common sign.
- R5: When the signs differ and |A| ≥ |B|, the result magnitude is |A|−|B| and the result sign is A's sign.
- R6: When the signs differ and |B| > |A|, a complement pass leaves the magnitude |B|−|A| and writes B's sign into bit 5 of the low character.
- R7: In the one-indicator configuration (`two_ind`=0), a carry out of the top digit sets bit 4 of the result's top character and sets `ovf1`.
- R8: In the two-indicator configuration with more than one digit, bits 5:4 of the top character form a count that each carry raises by one, saturating at 3. The first overflow sets `ovf1` and the next sets `ovf2`. `ovf2` never rises without `ovf1`.
- R9: A carry out of the top digit when the last available indicator is already set raises `alarm`, and the top character is not written.
- R10: A zone bit outside the allowed positions raises `alarm`. Bit 5 is allowed only in the low character, or in the high character of a multi-digit operand in the two-indicator configuration. Bit 4 is allowed only in the high character, except on a one-digit operand in the two-indicator configuration.
- R11: A digit code above 9 in either operand raises `alarm`.
- R12: A start with a digit count above MAX_N raises `alarm` on the next cycle and makes no memory access.
- R13: `alarm`, `ovf1` and `ovf2` are sticky until reset. While in alarm, `busy` is low and `start` is ignored.
- R14: `busy` is high while digits are processed. `done` is a single-cycle pulse that follows the final write, and `busy` is low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an add when idle |
| n_digits | input | CNT_W | Digits per operand |
| addr_a | input | ADDR_W | Low character of operand A and the result |
| addr_b | input | ADDR_W | Low character of operand B |
| two_ind | input | 1 | 1 selects two overflow indicators |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| alarm | output | 1 | Sticky stop on an illegal operand or a repeated overflow |
| ovf1 | output | 1 | Sticky first overflow indicator |
| ovf2 | output | 1 | Sticky second overflow indicator |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 6 | Write character |
| mem_rdata | input | 6 | Read character, valid one cycle after a read |

## Verification
The bench builds the unit with its default parameters: ADDR_W=8 and MAX_N=44. The 256-character memory holds two full 44-digit operands at the same time, so a carry can ripple through the widest legal operand. The 6-bit count input can still carry values from 45 to 63, which brings the out-of-range start of R12 within reach. Both indicator configurations are exercised, covering the saturating count, the second indicator and the alarm on a third carry.

// File: rtl/sma_pkg.sv
package sma_pkg;
  localparam int DIG_W  = 4;
  localparam int ZONE_W = 2;
  localparam int CHAR_W = DIG_W + ZONE_W;

  typedef struct packed {
    logic [ZONE_W-1:0] zone;
    logic [DIG_W-1:0]  digit;
  } char_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RDA, S_RDB, S_CALC, S_CRD, S_CWR, S_FIN, S_HALT
  } state_t;
endpackage

// File: rtl/sma_digit_alu.sv
module sma_digit_alu
  import sma_pkg::*;
(
  input  logic [DIG_W-1:0] a,
  input  logic [DIG_W-1:0] b,
  input  logic             cin,
  input  logic             sub,
  output logic [DIG_W-1:0] d,
  output logic             cout
);
  logic [DIG_W:0] t;

  always_comb begin
    if (sub) begin
      t    = {1'b0, a} - {1'b0, b} - {{DIG_W{1'b0}}, cin};
      cout = t[DIG_W];
      d    = cout ? DIG_W'(t + 5'd10) : t[DIG_W-1:0];
    end else begin
      t    = {1'b0, a} + {1'b0, b} + {{DIG_W{1'b0}}, cin};
      cout = (t > 5'd9);
      d    = cout ? DIG_W'(t - 5'd10) : t[DIG_W-1:0];
    end
  end
endmodule

// File: rtl/sma_zone_check.sv
module sma_zone_check
  import sma_pkg::*;
(
  input  logic [ZONE_W-1:0] zone,
  input  logic              first,
  input  logic              last,
  input  logic              ext,
  output logic              ok
);
  logic hi_ok, lo_ok;
  // bit 5: sign on the low char, or count MSB on a multi-digit high char
  assign hi_ok = first | (ext & last);
  // bit 4: overflow mark on the high char, barred on a one-digit extended operand
  assign lo_ok = last & ~(ext & first);
  assign ok    = (~zone[1] | hi_ok) & (~zone[0] | lo_ok);
endmodule

// File: rtl/serial_decimal_adder.sv
module serial_decimal_adder
  import sma_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int MAX_N  = 44,
  localparam int CNT_W = $clog2(MAX_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  n_digits,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic              two_ind,
  output logic              busy,
  output logic              done,
  output logic              alarm,
  output logic              ovf1,
  output logic              ovf2,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [CHAR_W-1:0] mem_wdata,
  input  logic [CHAR_W-1:0] mem_rdata
);
  state_t            st;
  logic [CNT_W-1:0]  n_q, rem_q;
  logic [ADDR_W-1:0] cur_a, cur_b, base_a;
  logic              ext_q, carry_q, sub_q, sign_b_q, ovf1_q, ovf2_q;
  char_t             a_q, rd_c, wr_c;

  logic              first, last, sub_now, ovfc, bad, fault;
  logic              alu_sub, alu_cout;
  logic [DIG_W-1:0]  alu_a, alu_b, alu_d;
  logic [1:0]        zone_ok;
  logic [ZONE_W-1:0] sat_zone;

  assign rd_c  = char_t'(mem_rdata);
  assign first = (rem_q == n_q);
  assign last  = (rem_q == CNT_W'(1));

  // one legality checker per operand
  for (genvar g = 0; g < 2; g++) begin : g_zchk
    sma_zone_check u_zc (
      .zone  (g == 0 ? a_q.zone : rd_c.zone),
      .first (first),
      .last  (last),
      .ext   (ext_q),
      .ok    (zone_ok[g])
    );
  end

  assign sub_now = first ? (a_q.zone[1] ^ rd_c.zone[1]) : sub_q;
  assign alu_a   = (st == S_CWR) ? '0 : a_q.digit;
  assign alu_b   = rd_c.digit;
  assign alu_sub = (st == S_CWR) ? 1'b1 : sub_now;

  sma_digit_alu u_alu (
    .a(alu_a), .b(alu_b), .cin(carry_q), .sub(alu_sub), .d(alu_d), .cout(alu_cout)
  );

  assign ovfc  = last & ~sub_now & alu_cout;
  assign fault = ~&zone_ok | (a_q.digit > 4'd9) | (rd_c.digit > 4'd9);
  assign bad   = fault | (ovfc & (ext_q ? ovf2_q : ovf1_q));
  assign sat_zone = (a_q.zone == 2'b11) ? 2'b11 : a_q.zone + {1'b0, ovfc};

  always_comb begin
    wr_c = '0;
    if (st == S_CWR) begin
      wr_c.digit = alu_d;
      wr_c.zone  = rd_c.zone;
      if (first) wr_c.zone[1] = sign_b_q;
    end else begin
      wr_c.digit = alu_d;
      if (first) wr_c.zone[1] = a_q.zone[1];
      if (last) begin
        if (ext_q && !first) wr_c.zone = sat_zone;
        else                 wr_c.zone[0] = a_q.zone[0] | ovfc;
      end
    end
  end

  always_comb begin
    mem_en   = 1'b0;
    mem_we   = 1'b0;
    mem_addr = cur_a;
    unique case (st)
      S_RDA, S_CRD: mem_en = 1'b1;
      S_RDB: begin mem_en = 1'b1; mem_addr = cur_b; end
      S_CALC: begin mem_en = ~bad; mem_we = ~bad; end
      S_CWR: begin mem_en = 1'b1; mem_we = 1'b1; end
      default: ;
    endcase
  end
  assign mem_wdata = wr_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      n_q <= '0; rem_q <= '0;
      cur_a <= '0; cur_b <= '0; base_a <= '0;
      ext_q <= 1'b0; carry_q <= 1'b0; sub_q <= 1'b0; sign_b_q <= 1'b0;
      ovf1_q <= 1'b0; ovf2_q <= 1'b0;
      a_q <= '0;
    end else begin
      unique case (st)
        S_IDLE, S_FIN: begin
          st <= S_IDLE;
          if (start) begin
            if (n_digits > CNT_W'(MAX_N)) st <= S_HALT;
            else if (n_digits == '0)      st <= S_FIN;
            else begin
              st <= S_RDA;
              n_q <= n_digits; rem_q <= n_digits;
              cur_a <= addr_a; base_a <= addr_a; cur_b <= addr_b;
              ext_q <= two_ind; carry_q <= 1'b0;
            end
          end
        end
        S_RDA: st <= S_RDB;
        S_RDB: begin a_q <= rd_c; st <= S_CALC; end
        S_CALC: begin
          if (bad) st <= S_HALT;
          else begin
            carry_q <= alu_cout;
            if (first) begin sub_q <= sub_now; sign_b_q <= rd_c.zone[1]; end
            if (ovfc) begin
              if (!ovf1_q) ovf1_q <= 1'b1;
              else         ovf2_q <= 1'b1;
            end
            cur_a <= cur_a - 1'b1;
            cur_b <= cur_b - 1'b1;
            rem_q <= rem_q - 1'b1;
            if (!last) st <= S_RDA;
            else if (sub_now && alu_cout) begin
              st <= S_CRD; cur_a <= base_a; rem_q <= n_q; carry_q <= 1'b0;
            end else st <= S_FIN;
          end
        end
        S_CRD: st <= S_CWR;
        S_CWR: begin
          carry_q <= alu_cout;
          cur_a <= cur_a - 1'b1;
          rem_q <= rem_q - 1'b1;
          st <= last ? S_FIN : S_CRD;
        end
        default: st <= S_HALT;
      endcase
    end
  end

  assign busy  = (st != S_IDLE) && (st != S_FIN) && (st != S_HALT);
  assign done  = (st == S_FIN);
  assign alarm = (st == S_HALT);
  assign ovf1  = ovf1_q;
  assign ovf2  = ovf2_q;
endmodule

// File: rtl/sma_checker.sv
module sma_checker #(
  parameter int MAX_N = 44,
  localparam int CNT_W = $clog2(MAX_N + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] n_digits,
  input logic             busy,
  input logic             done,
  input logic             alarm,
  input logic             ovf1,
  input logic             ovf2,
  input logic             mem_en,
  input logic             mem_we
);
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en && !mem_we);

  assert_zero_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !alarm && n_digits == '0) |=> done && !mem_en);

  assert_ovf_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf2 |-> ovf1);

  assert_big_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !alarm && n_digits > CNT_W'(MAX_N)) |=> alarm && !mem_en);

  assert_alarm_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |=> alarm && !busy);

  assert_ovf_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf1 |=> ovf1) and (ovf2 |=> ovf2));

  assert_done_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !alarm);
endmodule

bind serial_decimal_adder sma_checker #(.MAX_N(MAX_N)) u_chk (.*);

// File: tb/serial_decimal_adder_test.sv
module serial_decimal_adder_test;
  localparam int ADDR_W = 8;
  localparam int MAX_N  = 44;
  localparam int CNT_W  = $clog2(MAX_N + 1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, two_ind = 1'b0;
  logic [CNT_W-1:0] n_digits = '0;
  logic [ADDR_W-1:0] addr_a = '0, addr_b = '0;
  logic busy, done, alarm, ovf1, ovf2, mem_en, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [5:0] mem_wdata, mem_rdata;
  logic [5:0] mem [256];
  int checks = 0, errors = 0, accesses = 0;
  logic saw_busy, saw_done;

  always #2 clk = ~clk;

  serial_decimal_adder #(.ADDR_W(ADDR_W), .MAX_N(MAX_N)) uut (.*);

  always @(posedge clk) begin
    if (mem_en) begin
      accesses++;
      if (mem_we) mem[mem_addr] = mem_wdata;
      else mem_rdata <= mem[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic put_num(input int lsd, input int n, input int val, input bit neg, input logic [1:0] hiz);
    int v = val;
    for (int i = 0; i < n; i++) begin
      logic [5:0] c;
      c = {2'b00, 4'(v % 10)};
      v = v / 10;
      if (i == 0) c[5] = neg;
      if (i == n - 1) c[5:4] = c[5:4] | hiz;
      mem[lsd - i] = c;
    end
  endtask

  function automatic int mag(input int lsd, input int n);
    int v = 0;
    for (int i = n - 1; i >= 0; i--) v = v * 10 + int'(mem[lsd - i][3:0]);
    return v;
  endfunction

  task automatic run(input int n, input int a, input int b, input bit ext);
    @(negedge clk);
    n_digits = CNT_W'(n); addr_a = ADDR_W'(a); addr_b = ADDR_W'(b); two_ind = ext;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    saw_busy = 1'b0; saw_done = 1'b0;
    for (int k = 0; k < 1000; k++) begin
      if (busy) saw_busy = 1'b1;
      if (done || alarm) begin saw_done = done; break; end
      @(negedge clk);
    end
    if (done) begin
      @(negedge clk);
      chk(!done, "R14 done single pulse", done, 0);
    end
  endtask

  task automatic t_reset();
    chk(!busy && !done && !alarm, "R1 reset status", {busy, done, alarm}, 0);
    chk(!ovf1 && !ovf2, "R1 reset indicators", {ovf1, ovf2}, 0);
  endtask

  task automatic t_zero_len();
    int acc0;
    mem[50] = 6'h07;
    acc0 = accesses;
    run(0, 50, 60, 1'b0);
    chk(saw_done, "R2 done for zero count", saw_done, 1);
    chk(accesses == acc0, "R2 no memory access", accesses - acc0, 0);
    chk(mem[50] == 6'h07, "R2 memory untouched", mem[50], 7);
  endtask

  task automatic t_like_pos();
    put_num(20, 4, 1234, 1'b0, 2'b00);
    put_num(30, 4, 5678, 1'b0, 2'b00);
    run(4, 20, 30, 1'b0);
    chk(saw_busy && saw_done, "R14 busy then done", {saw_busy, saw_done}, 3);
    chk(mag(20, 4) == 6912, "R4 positive sum", mag(20, 4), 6912);
    chk(mem[17] == 6'd6, "R3 top digit at lowest address", mem[17], 6);
    chk(mem[20][5] == 1'b0, "R4 positive sign", mem[20][5], 0);
    chk(mag(30, 4) == 5678, "R3 operand B unchanged", mag(30, 4), 5678);
  endtask

  task automatic t_like_neg();
    put_num(40, 2, 25, 1'b1, 2'b00);
    put_num(45, 2, 17, 1'b1, 2'b00);
    run(2, 40, 45, 1'b0);
    chk(mag(40, 2) == 42, "R4 negative sum magnitude", mag(40, 2), 42);
    chk(mem[40][5] == 1'b1, "R4 negative sign kept", mem[40][5], 1);
  endtask

  task automatic t_unlike_a();
    put_num(60, 2, 83, 1'b0, 2'b00);
    put_num(65, 2, 21, 1'b1, 2'b00);
    run(2, 60, 65, 1'b0);
    chk(mag(60, 2) == 62, "R5 difference magnitude", mag(60, 2), 62);
    chk(mem[60][5] == 1'b0, "R5 sign of A", mem[60][5], 0);
  endtask

  task automatic t_unlike_b();
    put_num(70, 3, 12, 1'b0, 2'b00);
    put_num(75, 3, 45, 1'b1, 2'b00);
    run(3, 70, 75, 1'b0);
    chk(mag(70, 3) == 33, "R6 complemented magnitude", mag(70, 3), 33);
    chk(mem[70][5] == 1'b1, "R6 sign of B", mem[70][5], 1);
    put_num(80, 3, 7, 1'b1, 2'b00);
    put_num(85, 3, 300, 1'b0, 2'b00);
    run(3, 80, 85, 1'b0);
    chk(mag(80, 3) == 293 && mem[80][5] == 1'b0, "R6 positive B larger", mag(80, 3), 293);
  endtask

  task automatic t_long_carry();
    int zeros = 0;
    for (int i = 0; i < 44; i++) begin mem[100 - i] = 6'd9; mem[200 - i] = 6'd0; end
    mem[200] = 6'd1;
    run(44, 100, 200, 1'b0);
    for (int i = 0; i < 44; i++) if (mem[100 - i][3:0] == 4'd0) zeros++;
    chk(zeros == 44, "R7 full ripple to zero", zeros, 44);
    chk(mem[57] == 6'h10, "R7 top char overflow bit", mem[57], 16);
    chk(ovf1 && !ovf2, "R7 first indicator", {ovf1, ovf2}, 2);
  endtask

  task automatic t_second_ovf_single();
    put_num(110, 2, 99, 1'b0, 2'b01);
    put_num(115, 2, 1, 1'b0, 2'b00);
    run(2, 110, 115, 1'b0);
    chk(alarm, "R9 repeat overflow alarm", alarm, 1);
    chk(mem[109] == 6'h19, "R9 top char not written", mem[109], 25);
    chk(!busy, "R13 busy low in alarm", busy, 0);
    run(0, 50, 60, 1'b0);
    chk(!saw_done && alarm && ovf1, "R13 start ignored in alarm", saw_done, 0);
  endtask

  task automatic t_ext_count();
    do_reset();
    put_num(120, 2, 99, 1'b0, 2'b00);
    put_num(125, 2, 1, 1'b0, 2'b00);
    run(2, 120, 125, 1'b1);
    chk(mem[119] == 6'h10 && ovf1 && !ovf2, "R8 count one", mem[119], 16);
    put_num(120, 2, 99, 1'b0, 2'b01);
    run(2, 120, 125, 1'b1);
    chk(mem[119] == 6'h20 && ovf2, "R8 count two and second indicator", mem[119], 32);
    put_num(120, 2, 99, 1'b0, 2'b10);
    run(2, 120, 125, 1'b1);
    chk(alarm && mem[119] == 6'h29, "R9 third carry alarm", mem[119], 41);
  endtask

  task automatic t_bad_zone();
    do_reset();
    put_num(130, 3, 456, 1'b0, 2'b00);
    mem[129] = mem[129] | 6'h10;
    put_num(135, 3, 111, 1'b0, 2'b00);
    run(3, 130, 135, 1'b0);
    chk(alarm, "R10 middle zone bit", alarm, 1);
    do_reset();
    mem[140] = 6'h13; mem[141] = 6'h02;
    run(1, 140, 141, 1'b1);
    chk(alarm, "R10 one-digit extended bit 4", alarm, 1);
    do_reset();
    mem[142] = 6'h13; mem[143] = 6'h02;
    run(1, 142, 143, 1'b0);
    chk(!alarm && mem[142] == 6'h15, "R10 one-digit single bit 4 allowed", mem[142], 21);
  endtask

  task automatic t_bad_digit();
    do_reset();
    put_num(150, 2, 11, 1'b0, 2'b00);
    mem[155] = 6'h0A; mem[154] = 6'h01;
    run(2, 150, 155, 1'b0);
    chk(alarm, "R11 digit code above nine", alarm, 1);
  endtask

  task automatic t_big_n();
    int acc0;
    do_reset();
    acc0 = accesses;
    run(50, 20, 30, 1'b0);
    chk(alarm && accesses == acc0, "R12 count above limit", accesses - acc0, 0);
    do_reset();
    chk(!alarm && !ovf1, "R13 reset clears sticky", {alarm, ovf1}, 0);
  endtask

  initial begin
    #(4ns * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    do_reset();
    @(negedge clk);
    t_reset();
    t_zero_len();
    t_like_pos();
    t_like_neg();
    t_unlike_a();
    t_unlike_b();
    t_long_carry();
    t_second_ovf_single();
    t_ext_count();
    t_bad_zone();
    t_bad_digit();
    t_big_n();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule